// File: doc/BRIEF.md
# Vectored Interrupt Arbiter

The arbiter turns the flag and enable bits of the on-chip peripherals, two external interrupt lines and two software-raised sources (trap and illegal opcode) into a registered 32-bit pending mask. At every clock edge where the core reports an instruction boundary, it selects at most one source to service. The selection uses the core's two condition-code mask bits: `mask_i_i` gates ordinary sources and `mask_x_i` gates the non-maskable line.

For the selected source the block issues a one-cycle take strobe, the 5-bit source id, the 16-bit vector-fetch address and a request to set either the I or the X mask bit. It also reports the fixed 14-cycle overhead of taking an interrupt. The core does the stacking, the vector read and the mask-bit update.

Top module: `vec_int_arbiter`

## Requirements
- R1: After reset, and before any source is raised, `take_o`, `src_id_o`, `vec_addr_o`, `set_i_o`, `set_x_o` and `ovh_cyc_o` are 0, and a boundary takes nothing.
- R2: The flag/enable pair at bus index k feeds one source id: k=0..3 feed 11 (serial, sharing one id); 4 feeds 12; 5 feeds 15; 6 feeds 24; 7..11 feed 20,19,18,17,16; 12..14 feed 23,22,21; 15 feeds 13; 16 feeds 14. At each clock edge, a peripheral pending bit becomes 1 only if at least one of its pairs has both enable and flag set, and 0 otherwise.
- R3: Any single active pair among the four serial pairs keeps id 11 pending, whatever the state of the other three.
- R4: Trap (id 27) wins over everything, and then illegal opcode (id 28). Neither is gated by a mask bit, and each pending bit clears when that source is taken.
- R5: With non-maskable id 26 pending and `mask_x_i`=0, id 26 is taken and its pending bit clears. With `mask_x_i`=1, nothing at all is taken, even when lower sources are pending.
- R6: With `mask_i_i`=1, no source other than 26, 27 or 28 is taken.
- R7: Among the remaining sources the lowest pending id wins. Its pending bit follows its inputs and is not cleared by being taken.
- R8: `vec_addr_o` = base + 2*id, where the base is 0xFFC0, or 0xBFC0 when `special_mode_i` was 1 at the selecting edge.
- R9: A take of id 26 asserts `set_x_o` only. A take of any other id asserts `set_i_o` only.
- R10: `take_o` rises in the cycle after an edge where `boundary_i`=1 and a source qualified. It lasts one cycle unless the next edge also selects. Without a boundary, nothing is taken and no pending bit is consumed.
- R11: A raise input (`swi_raise_i`, `ill_raise_i`, `xirq_line_i`) that is high at the same edge as its source's clearing leaves the pending bit set.
- R12: `ovh_cyc_o` is 14 when `take_o`=1, and 0 otherwise.
- R13: The pending bit of id 25 follows `irq_line_i` as sampled at each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| flag_i | input | 17 | peripheral flag bits, one per pair |
| en_i | input | 17 | peripheral enable bits, one per pair |
| irq_line_i | input | 1 | maskable external line (id 25) |
| xirq_line_i | input | 1 | non-maskable line raise (id 26) |
| swi_raise_i | input | 1 | software trap raise (id 27) |
| ill_raise_i | input | 1 | illegal opcode raise (id 28) |
| boundary_i | input | 1 | instruction boundary from the core |
| mask_i_i | input | 1 | core I mask bit |
| mask_x_i | input | 1 | core X mask bit |
| special_mode_i | input | 1 | selects the alternate vector base |
| take_o | output | 1 | interrupt taken strobe |
| src_id_o | output | 5 | id of the taken source |
| vec_addr_o | output | 16 | vector fetch address |
| set_i_o | output | 1 | request to set I |
| set_x_o | output | 1 | request to set X |
| ovh_cyc_o | output | 4 | cycles of take overhead |

## Verification
The bench targets four failure modes:
- A blocked non-maskable line with ordinary sources also pending. A design that falls through the chain would wrongly take the lower source while X is set.
- The serial pairs dropping one at a time. A design that lets the last-evaluated pair decide would lose id 11 while another pair is still active.
- Trap and illegal opcode raised together under I=1. A correct design takes id 27 and then id 28. A design that masks them, or fails to consume them, would take nothing or the same id twice.
- A raise coinciding with its own clear. A design that lets the clear win would drop the second trap.

Boundary-free cycles check that a source is never consumed without a take.

// File: rtl/vec_int_arbiter_pkg.sv
package vec_int_arbiter_pkg;
  localparam int NUM_SRC  = 32;
  localparam int ID_W     = $clog2(NUM_SRC);
  localparam int NUM_PAIR = 17;
  localparam int TAKE_CYC = 14;
  localparam int OVH_W    = $clog2(TAKE_CYC + 1);

  localparam int ID_SER  = 11;
  localparam int ID_SPI  = 12;
  localparam int ID_PAI  = 13;
  localparam int ID_PAO  = 14;
  localparam int ID_TOF  = 15;
  localparam int ID_OC5  = 16;
  localparam int ID_IC3  = 21;
  localparam int ID_RTI  = 24;
  localparam int ID_IRQ  = 25;
  localparam int ID_NMI  = 26;
  localparam int ID_TRAP = 27;
  localparam int ID_ILL  = 28;

  // pair index -> pending id; serial pairs share one id
  function automatic logic [ID_W-1:0] pair_src(input int k);
    int r;
    if (k < 4)                 r = ID_SER;
    else if (k == 4)           r = ID_SPI;
    else if (k == 5)           r = ID_TOF;
    else if (k == 6)           r = ID_RTI;
    else if (k >= 7 && k < 12) r = ID_OC5 + (11 - k);
    else if (k >= 12 && k < 15) r = ID_IC3 + (14 - k);
    else if (k == 15)          r = ID_PAI;
    else                       r = ID_PAO;
    return ID_W'(r);
  endfunction

  function automatic logic is_unmaskable(input int i);
    return (i == ID_NMI) || (i == ID_TRAP) || (i == ID_ILL);
  endfunction
endpackage

// File: rtl/vec_int_pend_collect.sv
module vec_int_pend_collect
  import vec_int_arbiter_pkg::*;
#(
  parameter int NPAIR = NUM_PAIR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NPAIR-1:0]   flag_i,
  input  logic [NPAIR-1:0]   en_i,
  input  logic               irq_line_i,
  input  logic               xirq_line_i,
  input  logic               swi_raise_i,
  input  logic               ill_raise_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NPAIR-1:0]   act;
  logic [NUM_SRC-1:0] set_v, pend_d, pend_q;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign act[k] = en_i[k] & flag_i[k];
  end

  // all peripheral ids start cleared; any active pair sets its id
  always_comb begin
    set_v = '0;
    for (int k = 0; k < NPAIR; k++)
      if (act[k]) set_v[pair_src(k)] = 1'b1;
  end

  always_comb begin
    pend_d          = set_v;
    pend_d[ID_IRQ]  = irq_line_i;
    pend_d[ID_NMI]  = xirq_line_i | (pend_q[ID_NMI]  & ~clr_i[ID_NMI]);
    pend_d[ID_TRAP] = swi_raise_i | (pend_q[ID_TRAP] & ~clr_i[ID_TRAP]);
    pend_d[ID_ILL]  = ill_raise_i | (pend_q[ID_ILL]  & ~clr_i[ID_ILL]);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;

  assign pend_o = pend_q;
endmodule

// File: rtl/vec_int_select.sv
module vec_int_select
  import vec_int_arbiter_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               mask_i_i,
  input  logic               mask_x_i,
  output logic               valid_o,
  output logic [ID_W-1:0]    id_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic [ID_W-1:0] pick;
  logic            hit;

  // lowest maskable pending id
  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend_i[i] && !is_unmaskable(i)) begin
        pick = ID_W'(i);
        hit  = 1'b1;
      end
  end

  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    clr_o   = '0;
    if (pend_i[ID_TRAP]) begin
      valid_o = 1'b1; id_o = ID_W'(ID_TRAP); clr_o[ID_TRAP] = 1'b1;
    end else if (pend_i[ID_ILL]) begin
      valid_o = 1'b1; id_o = ID_W'(ID_ILL); clr_o[ID_ILL] = 1'b1;
    end else if (pend_i[ID_NMI]) begin
      // held-off NMI blocks everything below it
      if (!mask_x_i) begin
        valid_o = 1'b1; id_o = ID_W'(ID_NMI); clr_o[ID_NMI] = 1'b1;
      end
    end else if (!mask_i_i && hit) begin
      valid_o = 1'b1; id_o = pick;
    end
  end
endmodule

// File: rtl/vec_int_arbiter.sv
module vec_int_arbiter
  import vec_int_arbiter_pkg::*;
#(
  parameter int          NPAIR     = NUM_PAIR,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] NORM_BASE = 16'hFFC0,
  parameter logic [15:0] SPEC_BASE = 16'hBFC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPAIR-1:0]  flag_i,
  input  logic [NPAIR-1:0]  en_i,
  input  logic              irq_line_i,
  input  logic              xirq_line_i,
  input  logic              swi_raise_i,
  input  logic              ill_raise_i,
  input  logic              boundary_i,
  input  logic              mask_i_i,
  input  logic              mask_x_i,
  input  logic              special_mode_i,
  output logic              take_o,
  output logic [ID_W-1:0]   src_id_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              set_i_o,
  output logic              set_x_o,
  output logic [OVH_W-1:0]  ovh_cyc_o
);
  logic [NUM_SRC-1:0] pend, sel_clr, clr;
  logic               sel_valid, take_d;
  logic [ID_W-1:0]    sel_id;
  logic [ADDR_W-1:0]  base, vec_d;

  vec_int_pend_collect #(.NPAIR(NPAIR)) u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_i     (flag_i),
    .en_i       (en_i),
    .irq_line_i (irq_line_i),
    .xirq_line_i(xirq_line_i),
    .swi_raise_i(swi_raise_i),
    .ill_raise_i(ill_raise_i),
    .clr_i      (clr),
    .pend_o     (pend)
  );

  vec_int_select u_select (
    .pend_i  (pend),
    .mask_i_i(mask_i_i),
    .mask_x_i(mask_x_i),
    .valid_o (sel_valid),
    .id_o    (sel_id),
    .clr_o   (sel_clr)
  );

  assign take_d = boundary_i & sel_valid;
  assign clr    = take_d ? sel_clr : '0;
  assign base   = special_mode_i ? ADDR_W'(SPEC_BASE) : ADDR_W'(NORM_BASE);
  assign vec_d  = base + ADDR_W'({sel_id, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o     <= 1'b0;
      src_id_o   <= '0;
      vec_addr_o <= '0;
      set_i_o    <= 1'b0;
      set_x_o    <= 1'b0;
      ovh_cyc_o  <= '0;
    end else begin
      take_o     <= take_d;
      src_id_o   <= take_d ? sel_id : '0;
      vec_addr_o <= take_d ? vec_d : '0;
      set_x_o    <= take_d && (sel_id == ID_W'(ID_NMI));
      set_i_o    <= take_d && (sel_id != ID_W'(ID_NMI));
      ovh_cyc_o  <= take_d ? OVH_W'(TAKE_CYC) : '0;
    end
  end
endmodule

// File: rtl/vec_int_arbiter_chk.sv
module vec_int_arbiter_chk
  import vec_int_arbiter_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] NORM_BASE = 16'hFFC0,
  parameter logic [15:0] SPEC_BASE = 16'hBFC0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              boundary_i,
  input logic              mask_i_i,
  input logic              mask_x_i,
  input logic              special_mode_i,
  input logic              take_o,
  input logic [ID_W-1:0]   src_id_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              set_i_o,
  input logic              set_x_o,
  input logic [OVH_W-1:0]  ovh_cyc_o
);
  assert_take_needs_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));

  assert_one_mask_request_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (set_i_o != set_x_o));

  assert_no_request_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (!set_i_o && !set_x_o));

  assert_x_request_is_nmi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_x_o |-> (src_id_o == ID_W'(ID_NMI)));

  assert_vector_address_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_addr_o == ADDR_W'(($past(special_mode_i) ? SPEC_BASE : NORM_BASE)
                                       + {src_id_o, 1'b0})));

  assert_x_blocks_nmi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(mask_x_i)) |-> (src_id_o != ID_W'(ID_NMI)));

  assert_i_blocks_rest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(mask_i_i)) |-> (src_id_o >= ID_W'(ID_NMI)));

  assert_overhead_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovh_cyc_o == (take_o ? OVH_W'(TAKE_CYC) : '0));
endmodule

bind vec_int_arbiter vec_int_arbiter_chk #(
  .ADDR_W(ADDR_W), .NORM_BASE(NORM_BASE), .SPEC_BASE(SPEC_BASE)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .boundary_i    (boundary_i),
  .mask_i_i      (mask_i_i),
  .mask_x_i      (mask_x_i),
  .special_mode_i(special_mode_i),
  .take_o        (take_o),
  .src_id_o      (src_id_o),
  .vec_addr_o    (vec_addr_o),
  .set_i_o       (set_i_o),
  .set_x_o       (set_x_o),
  .ovh_cyc_o     (ovh_cyc_o)
);

// File: tb/vec_int_arbiter_tb_top.sv
`timescale 1ns/1ps
module vec_int_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] flag = '0, en = '0;
  logic        irq = 0, xirq = 0, swi = 0, ill = 0, bnd = 0, mi = 0, mx = 0, spec = 0;
  logic        take_o, set_i_o, set_x_o;
  logic [4:0]  src_id_o;
  logic [15:0] vec_addr_o;
  logic [3:0]  ovh_cyc_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_int_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flag_i(flag), .en_i(en),
    .irq_line_i(irq), .xirq_line_i(xirq), .swi_raise_i(swi), .ill_raise_i(ill),
    .boundary_i(bnd), .mask_i_i(mi), .mask_x_i(mx), .special_mode_i(spec),
    .take_o(take_o), .src_id_o(src_id_o), .vec_addr_o(vec_addr_o),
    .set_i_o(set_i_o), .set_x_o(set_x_o), .ovh_cyc_o(ovh_cyc_o)
  );

  // reference model
  int pair_id [17] = '{11,11,11,11,12,15,24,20,19,18,17,16,23,22,21,13,14};
  bit [31:0] m_pend, nxt;
  int w, e_take, e_id, e_vec, e_si, e_sx, e_ovh;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; e_take = 0; e_id = 0; e_vec = 0; e_si = 0; e_sx = 0; e_ovh = 0;
    end else begin
      w = -1;
      if (m_pend[27]) w = 27;
      else if (m_pend[28]) w = 28;
      else if (m_pend[26]) w = mx ? -1 : 26;
      else if (!mi) begin
        for (int i = 0; i < 32; i++) if (w < 0 && m_pend[i] && i != 26 && i != 27 && i != 28) w = i;
      end
      if (!bnd) w = -1;
      nxt = m_pend;
      foreach (pair_id[k]) nxt[pair_id[k]] = 1'b0;
      foreach (pair_id[k]) if (en[k] && flag[k]) nxt[pair_id[k]] = 1'b1;
      nxt[25] = irq;
      if (w >= 26) nxt[w] = 1'b0;
      if (xirq) nxt[26] = 1'b1;
      if (swi)  nxt[27] = 1'b1;
      if (ill)  nxt[28] = 1'b1;
      m_pend = nxt;
      e_take = (w >= 0);
      e_id   = e_take ? w : 0;
      e_vec  = e_take ? ((spec ? 'hBFC0 : 'hFFC0) + 2 * w) : 0;
      e_sx   = e_take && w == 26;
      e_si   = e_take && w != 26;
      e_ovh  = e_take ? 14 : 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 take_o", take_o, e_take);
      chk("R7 src_id_o", src_id_o, e_id);
      chk("R8 vec_addr_o", vec_addr_o, e_vec);
      chk("R9 set_i_o", set_i_o, e_si);
      chk("R9 set_x_o", set_x_o, e_sx);
      chk("R12 ovh_cyc_o", ovh_cyc_o, e_ovh);
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fire();
    bnd = 1; step(); bnd = 0;
  endtask

  task automatic exp_take(string tag, int id);
    chk({tag, " take"}, take_o, 1);
    chk({tag, " id"}, src_id_o, id);
  endtask

  task automatic exp_none(string tag);
    chk({tag, " no take"}, take_o, 0);
  endtask

  task automatic quiet();
    flag = '0; en = '0; irq = 0; xirq = 0; swi = 0; ill = 0; mi = 0; mx = 0; spec = 0;
    step(); step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset take", take_o, 0);
    chk("R1 reset vec", vec_addr_o, 0);
    chk("R1 reset ovh", ovh_cyc_o, 0);
    fire(); exp_none("R1 empty");

    // R2: output-compare 1 is pair 7 -> id 20
    flag[7] = 1; step(); fire(); exp_none("R2 flag w/o enable");
    en[7] = 1; step(); fire(); exp_take("R2 oc1", 20);
    chk("R8 vec oc1", vec_addr_o, 'hFFE8);
    chk("R9 set_i oc1", set_i_o, 1);
    chk("R12 overhead", ovh_cyc_o, 14);
    step(); chk("R10 strobe one cycle", take_o, 0);
    fire(); exp_take("R7 stays pending", 20);
    quiet();

    // R3: shared serial id 11
    en[3:0] = 4'hF; flag[0] = 1; flag[2] = 1; step();
    flag[0] = 0; step(); fire(); exp_take("R3 serial one pair", 11);
    flag[2] = 0; flag[3] = 1; step(); fire(); exp_take("R3 serial idle pair", 11);
    flag[3] = 0; step(); fire(); exp_none("R3 serial none");
    quiet();

    // R7: lowest id wins; R10 no boundary
    en[4] = 1; flag[4] = 1; en[6] = 1; flag[6] = 1; step();
    repeat (3) begin step(); exp_none("R10 no boundary"); end
    fire(); exp_take("R7 spi over rti", 12);
    flag[4] = 0; step(); fire(); exp_take("R7 rti", 24);
    spec = 1; flag[4] = 1; step(); fire(); exp_take("R8 special", 12);
    chk("R8 special vec", vec_addr_o, 'hBFC0 + 24);
    spec = 0;
    mi = 1; fire(); exp_none("R6 I masks");

    // R4: trap and illegal under I=1
    swi = 1; ill = 1; step(); swi = 0; ill = 0;
    fire(); exp_take("R4 trap first", 27);
    fire(); exp_take("R4 illegal next", 28);
    fire(); exp_none("R4 consumed");

    // R11: raise during its own clear
    swi = 1; step(); fire(); exp_take("R11 trap", 27);
    swi = 0; fire(); exp_take("R11 raise kept", 27);
    fire(); exp_none("R11 then gone");

    // R5: blocked NMI with SPI pending, I=0
    mi = 0; mx = 1; xirq = 1; step(); xirq = 0;
    fire(); exp_none("R5 X blocks all");
    fire(); exp_none("R5 still blocked");
    mx = 0; fire(); exp_take("R5 nmi", 26);
    chk("R9 set_x nmi", set_x_o, 1);
    chk("R8 vec nmi", vec_addr_o, 'hFFC0 + 52);
    fire(); exp_take("R5 cleared then spi", 12);
    quiet();

    // R13: maskable line
    irq = 1; step(); fire(); exp_take("R13 irq", 25);
    irq = 0; step(); fire(); exp_none("R13 irq low");

    // back-to-back boundaries with several sources
    en = '1; flag = 17'h1F0F0; step();
    bnd = 1; repeat (6) step();
    flag = 17'h00F00; repeat (3) step();
    bnd = 0; quiet();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule